// File: doc/BRIEF.md
# Interrupt Request Capture and Priority Resolver

This block watches a set of interrupt request lines and keeps one pending bit for each line. A per-line trigger selection decides how each bit is captured. In level mode the pending bit tracks the line. In edge mode the bit latches on a low-to-high transition, which is detected against a stored copy of the previous line level. A separate pulse interface lets neighbouring acknowledge logic force individual pending bits on or off within a cycle.

From the pending bits that the interrupt mask leaves enabled, a rotating-priority resolver picks the best one. The line at the rotation base ranks first, and rank grows upward from there with wrap-around. The winner is compared against the best in-service line, ranked with the same rotation. A request is raised only when the winner ranks strictly better. When nested mode is selected on the master unit, the cascade line's in-service bit is left out of that comparison. The raise flag and the winning line number are registered. A line controller places this block between its request pins and its register and acknowledge logic.

Top module: `irq_prio_resolver`

## Requirements
- R1: For a line whose trigger select bit is 1 (level mode), the pending bit after a clock edge equals the line value sampled at that edge, unless a set or clear pulse acts on it.
- R2: For a line whose trigger select bit is 0 (edge mode), the pending bit becomes 1 when the line is high at an edge after being low at the previous edge. A line that is held high or that falls never clears the pending bit.
- R3: Rank 0 belongs to line `rot_base`, rank 1 to line `rot_base+1`, and so on modulo the line count. The best candidate is the one with the lowest rank, and `req_line` reports its line number.
- R4: Candidates are the pending bits whose `irq_mask` bit is 0. With no candidate, `req_valid` is 0. Whenever `req_valid` is 0, `req_line` is 0.
- R5: `req_valid` is 1 only when the best candidate's rank is strictly lower than the lowest rank among the set `in_service` bits. An in-service bit on the same line or on a better line blocks the request.
- R6: When `nested_mode` and `is_master` are both 1, in-service bit 2 (the cascade line) is ignored when the in-service rank is computed.
- R7: A `pend_clr` bit clears its pending bit at the next edge. It overrides `pend_set` and the line capture in that cycle.
- R8: A `pend_set` bit without the matching `pend_clr` bit sets its pending bit at the next edge.
- R9: While `rst` is high, the pending bits, the stored last levels and `req_valid` are all cleared.
- R10: A line change is visible in `pend_q` after one rising edge. `req_valid` and `req_line` reflect the pending state and the other inputs one rising edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Interrupt request lines |
| trig_level | input | N_LINES | Per-line trigger select: 1 level, 0 edge |
| irq_mask | input | N_LINES | 1 removes the line from the candidates |
| in_service | input | N_LINES | Lines currently being serviced |
| rot_base | input | log2(N_LINES) | Line that holds rank 0 |
| nested_mode | input | 1 | Nested mode selected |
| is_master | input | 1 | This unit is the master of a cascade |
| pend_set | input | N_LINES | One-cycle set pulses for pending bits |
| pend_clr | input | N_LINES | One-cycle clear pulses for pending bits, dominant |
| pend_q | output | N_LINES | Pending-request register |
| req_valid | output | 1 | Registered raise decision |
| req_line | output | log2(N_LINES) | Registered winning line, 0 when not raising |

## Verification
Several properties are checked on every cycle. Level-mode pending bits track the line. Edge-mode bits never drop without a clear. Clear dominates set, and set takes effect. A raised line was an unmasked candidate and is not blocked by its own in-service bit, except for the excluded cascade line. A pending line at the rotation base always wins. An idle output reports line 0. The bench scenarios are the only place to show the exact winner under several rotations, the strict-rank comparison against in-service lines, the rising-edge-only capture after a clear, the level reassertion after a clear, and the one-edge latency of each stage.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_LINES_DEF   = 8;
  localparam int unsigned CASCADE_IDX_DEF = 2;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned N = irq_pkg::IRQ_LINES_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line_in,
  input  logic [N-1:0] trig_sel,
  input  logic [N-1:0] set_in,
  input  logic [N-1:0] clr_in,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] last_q;
  logic [N-1:0] pend_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic cap;
    // level lines follow the input; edge lines accumulate rising edges
    assign cap = (trig_sel[i] == irq_pkg::TRIG_LEVEL) ? line_in[i]
               : (pend_q[i] | (line_in[i] & ~last_q[i]));
    assign pend_d[i] = (cap | set_in[i]) & ~clr_in[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      last_q <= '0;
    end else begin
      pend_q <= pend_d;
      last_q <= line_in;
    end
  end
endmodule

// File: rtl/irq_rank_enc.sv
module irq_rank_enc #(
  parameter int unsigned N  = irq_pkg::IRQ_LINES_DEF,
  parameter int unsigned LW = $clog2(N),
  parameter int unsigned RW = LW + 1
) (
  input  logic [N-1:0]  req,
  input  logic [LW-1:0] base,
  output logic [RW-1:0] rank
);
  logic [N-1:0] rot;

  // rotate so that the line at base lands on position 0
  for (genvar i = 0; i < N; i++) begin : g_rot
    logic [LW-1:0] src;
    assign src    = LW'(i) + base;
    assign rot[i] = req[src];
  end

  // lowest set position is the best rank; N means none
  always_comb begin
    rank = RW'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) rank = RW'(k);
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int unsigned N_LINES      = irq_pkg::IRQ_LINES_DEF,
  parameter int unsigned CASCADE_LINE = irq_pkg::CASCADE_IDX_DEF,
  localparam int unsigned LW = $clog2(N_LINES),
  localparam int unsigned RW = LW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [N_LINES-1:0] trig_level,
  input  logic [N_LINES-1:0] irq_mask,
  input  logic [N_LINES-1:0] in_service,
  input  logic [LW-1:0]      rot_base,
  input  logic               nested_mode,
  input  logic               is_master,
  input  logic [N_LINES-1:0] pend_set,
  input  logic [N_LINES-1:0] pend_clr,
  output logic [N_LINES-1:0] pend_q,
  output logic               req_valid,
  output logic [LW-1:0]      req_line
);
  localparam logic [N_LINES-1:0] CASC_BIT = N_LINES'(1) << CASCADE_LINE;

  logic [N_LINES-1:0] cand;
  logic [N_LINES-1:0] isr_eff;
  logic [RW-1:0]      cand_rank;
  logic [RW-1:0]      isr_rank;
  logic               raise;
  logic [LW-1:0]      win_line;

  irq_capture #(.N(N_LINES)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .line_in (irq_in),
    .trig_sel(trig_level),
    .set_in  (pend_set),
    .clr_in  (pend_clr),
    .pend_q  (pend_q)
  );

  assign cand    = pend_q & ~irq_mask;
  assign isr_eff = (nested_mode && is_master) ? (in_service & ~CASC_BIT) : in_service;

  irq_rank_enc #(.N(N_LINES)) u_cand_rank (
    .req (cand),
    .base(rot_base),
    .rank(cand_rank)
  );

  irq_rank_enc #(.N(N_LINES)) u_isr_rank (
    .req (isr_eff),
    .base(rot_base),
    .rank(isr_rank)
  );

  assign raise    = cand_rank < isr_rank;
  assign win_line = cand_rank[LW-1:0] + rot_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_line  <= '0;
    end else begin
      req_valid <= raise;
      req_line  <= raise ? win_line : '0;
    end
  end
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
  parameter int unsigned N_LINES      = irq_pkg::IRQ_LINES_DEF,
  parameter int unsigned CASCADE_LINE = irq_pkg::CASCADE_IDX_DEF,
  localparam int unsigned LW = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] irq_in,
  input logic [N_LINES-1:0] trig_level,
  input logic [N_LINES-1:0] irq_mask,
  input logic [N_LINES-1:0] in_service,
  input logic [LW-1:0]      rot_base,
  input logic               nested_mode,
  input logic               is_master,
  input logic [N_LINES-1:0] pend_set,
  input logic [N_LINES-1:0] pend_clr,
  input logic [N_LINES-1:0] pend_q,
  input logic               req_valid,
  input logic [LW-1:0]      req_line
);
  localparam logic [LW-1:0] CASC_IDX = LW'(CASCADE_LINE);

  logic [N_LINES-1:0] cand_d;
  logic [N_LINES-1:0] isr_d;
  logic               skip_d;
  logic [LW-1:0]      rot_d;

  always_ff @(posedge clk) begin
    cand_d <= pend_q & ~irq_mask;
    isr_d  <= in_service;
    skip_d <= nested_mode && is_master;
    rot_d  <= rot_base;
  end

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (trig_level & ~pend_clr & ~pend_set) != '0 |=>
      ((pend_q ^ $past(irq_in)) & $past(trig_level & ~pend_clr & ~pend_set)) == '0); // R1

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~trig_level & ~pend_clr) != '0 |=>
      (~pend_q & $past(pend_q & ~trig_level & ~pend_clr)) == '0); // R2

  AST_CLR_DOMINATES: assert property (@(posedge clk) disable iff (rst)
    pend_clr != '0 |=> (pend_q & $past(pend_clr)) == '0); // R7

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (pend_set & ~pend_clr) != '0 |=> (~pend_q & $past(pend_set & ~pend_clr)) == '0); // R8

  AST_WIN_IS_CAND: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> cand_d[req_line]); // R4

  AST_IDLE_LINE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> req_line == '0); // R4

  AST_BASE_WINS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cand_d[rot_d]) |-> req_line == rot_d); // R3

  AST_NOT_OWN_SERVICE: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (!isr_d[req_line] || (skip_d && req_line == CASC_IDX))); // R5 R6

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend_q == '0 && !req_valid)); // R9
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(
  .N_LINES     (N_LINES),
  .CASCADE_LINE(CASCADE_LINE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_in     (irq_in),
  .trig_level (trig_level),
  .irq_mask   (irq_mask),
  .in_service (in_service),
  .rot_base   (rot_base),
  .nested_mode(nested_mode),
  .is_master  (is_master),
  .pend_set   (pend_set),
  .pend_clr   (pend_clr),
  .pend_q     (pend_q),
  .req_valid  (req_valid),
  .req_line   (req_line)
);

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0, trig_level = '0, irq_mask = '0, in_service = '0;
  logic [7:0] pend_set = '0, pend_clr = '0;
  logic [2:0] rot_base = '0;
  logic       nested_mode = 1'b0, is_master = 1'b0;
  logic [7:0] pend_q;
  logic       req_valid;
  logic [2:0] req_line;

  int total = 0;
  int bad   = 0;

  typedef struct {
    string      tag;
    logic [7:0] pend;
    logic       vld;
    logic [2:0] ln;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;

  logic [7:0] m_pend = '0;
  logic [7:0] m_last = '0;

  irq_prio_resolver u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .trig_level(trig_level),
    .irq_mask(irq_mask), .in_service(in_service), .rot_base(rot_base),
    .nested_mode(nested_mode), .is_master(is_master),
    .pend_set(pend_set), .pend_clr(pend_clr),
    .pend_q(pend_q), .req_valid(req_valid), .req_line(req_line)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic model_step(input logic [7:0] in_v, lvl, set_v, clr_v);
    for (int i = 0; i < 8; i++) begin
      logic c;
      c = lvl[i] ? in_v[i] : (m_pend[i] | (in_v[i] & ~m_last[i]));
      m_pend[i] = (c | set_v[i]) & ~clr_v[i];
    end
    m_last = in_v;
  endtask

  task automatic model_resolve(input logic [7:0] p, msk, isr, input logic [2:0] rot,
                               input logic skip, output logic v, output logic [2:0] ln);
    logic [7:0] cand, isr_e;
    int rc, ri;
    cand  = p & ~msk;
    isr_e = skip ? (isr & 8'hFB) : isr;
    rc = 8;
    ri = 8;
    for (int r = 7; r >= 0; r--) begin
      if (cand[(r + rot) % 8])  rc = r;
      if (isr_e[(r + rot) % 8]) ri = r;
    end
    v  = rc < ri;
    ln = v ? 3'((rc + rot) % 8) : 3'd0;
  endtask

  task automatic check(input string tag, input logic [7:0] ap, ep, input logic av, ev,
                       input logic [2:0] al, el);
    total++;
    if (ap !== ep || av !== ev || al !== el) begin
      bad++;
      $display("FAIL %s: pend=%h valid=%b line=%0d expected pend=%h valid=%b line=%0d",
               tag, ap, av, al, ep, ev, el);
    end
  endtask

  // driver: applies a stimulus for three cycles, pushes the expected result
  task automatic drive(input string tag, input logic [7:0] in_v, lvl, msk, isr,
                       input logic [2:0] rot, input logic nest, mst,
                       input logic [7:0] set_v, clr_v);
    exp_t e;
    logic v;
    logic [2:0] ln;
    @(negedge clk);
    irq_in = in_v; trig_level = lvl; irq_mask = msk; in_service = isr;
    rot_base = rot; nested_mode = nest; is_master = mst;
    pend_set = set_v; pend_clr = clr_v;
    model_step(in_v, lvl, set_v, clr_v);
    @(negedge clk);
    pend_set = '0; pend_clr = '0;
    model_step(in_v, lvl, 8'h00, 8'h00);
    @(negedge clk);
    model_resolve(m_pend, msk, isr, rot, nest && mst, v, ln);
    model_step(in_v, lvl, 8'h00, 8'h00);
    @(negedge clk);
    e.tag = tag; e.pend = m_pend; e.vld = v; e.ln = ln;
    exp_q.push_back(e);
    ->chk_ev;
  endtask

  // monitor: pops one expectation per trigger and compares with the outputs
  initial begin
    forever begin
      exp_t e;
      @(chk_ev);
      e = exp_q.pop_front();
      check(e.tag, pend_q, e.pend, req_valid, e.vld, req_line, e.ln);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset state", pend_q, 8'h00, req_valid, 1'b0, req_line, 3'd0);
    rst = 1'b0;

    // R10 latency: pending after one edge, raise after the next
    @(negedge clk);
    irq_in = 8'h08;
    model_step(8'h08, 8'h00, 8'h00, 8'h00);
    @(negedge clk);
    check("R10 pend after one edge", pend_q, 8'h08, req_valid, 1'b0, req_line, 3'd0);
    model_step(8'h08, 8'h00, 8'h00, 8'h00);
    @(negedge clk);
    check("R10 raise after second edge", pend_q, 8'h08, req_valid, 1'b1, req_line, 3'd3);
    model_step(8'h08, 8'h00, 8'h00, 8'h00);

    drive("R2 rise line5, line3 cleared", 8'h20, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 8'h08);
    drive("R1 level line3 high wins",     8'h28, 8'h08, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
    drive("R1 R2 level drop, edge fall",  8'h00, 8'h08, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
    drive("R4 masked line",               8'h00, 8'h08, 8'h20, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
    drive("R4 R7 empty after clear",      8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 8'h20);
    drive("R2 R3 rise lines1,6 base0",    8'h42, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
    drive("R3 base4",                     8'h42, 8'h00, 8'h00, 8'h00, 3'd4, 1'b0, 1'b0, 8'h00, 8'h00);
    drive("R3 base7 wrap",                8'h42, 8'h00, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0, 8'h00, 8'h00);
    drive("R5 better in service blocks",  8'h42, 8'h00, 8'h00, 8'h01, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
    drive("R5 worse in service passes",   8'h42, 8'h00, 8'h00, 8'h40, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
    drive("R5 same line blocks",          8'h42, 8'h00, 8'h00, 8'h02, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
    drive("R7 R2 clear, held high no set",8'h42, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 8'h42);
    drive("R6 cascade ignored on master", 8'h52, 8'h00, 8'h00, 8'h04, 3'd0, 1'b1, 1'b1, 8'h00, 8'h00);
    drive("R6 cascade counted on slave",  8'h52, 8'h00, 8'h00, 8'h04, 3'd0, 1'b1, 1'b0, 8'h00, 8'h00);
    drive("R7 clear beats set",           8'h52, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'h01, 8'h01);
    drive("R8 set pulse",                 8'h52, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'h01, 8'h00);
    drive("R1 R7 level reasserts",        8'hD2, 8'h80, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 8'h80);
    drive("R3 R1 base7 level line wins",  8'hD2, 8'h80, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0, 8'h00, 8'h00);

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule